// File: doc/BRIEF.md
# 4x4 Hadamard SATD and Mode Cost Unit

This unit measures how well one 4x4 predicted block matches its original pixels. It forms the residual (original minus predictor) and takes it through a separable two-dimensional 4x4 Hadamard transform built from add/subtract butterflies. It sums the absolute values of all sixteen coefficients and halves the result to give the SATD. It then adds a rate penalty to form the low-complexity mode cost. The penalty is lambda times the number of bits that carry the mode information.

A subsample switch reduces the work done on the residual. When the switch is on, only half of the residual positions are used, and each one is copied into its horizontal neighbour. Even rows take columns 0 and 2. Odd rows take columns 1 and 3. This gives a quincunx pattern that trades a little accuracy for less computation upstream.

The unit is fully pipelined. It takes one block on every cycle and returns its results exactly three cycles later. A mode-decision loop can therefore stream candidate predictors through it back to back.

Top module: `satd4x4`

## Requirements
- R1: While reset is held, and after it is released, `satd_valid` and `cost_valid` are low and `satd_out` and `cost_out` are zero until the first accepted block reaches the output.
- R2: A block presented with `in_valid` high at a rising clock edge produces `satd_valid` and `cost_valid` high after the third rising edge that follows. A new block can be accepted on every cycle.
- R3: With `sub_en` low, `satd_out` equals the sum of |H·D·Hᵀ| over all 16 coefficients, shifted right by 1. Here D[y][x] = orig − pred. Pixel (y,x) sits at bits [(4y+x)·8 +: 8] of each 128-bit bus. H is the 4x4 Hadamard matrix with rows (1,1,1,1), (1,1,−1,−1), (1,−1,−1,1) and (1,−1,1,−1).
- R4: With `sub_en` high, D[y][x] is replaced by the residual at column (x with bit 0 cleared) OR (y bit 0). Residuals at other positions then have no effect on the result.
- R5: `cost_out` equals `satd_out` + `lambda` × `mode_bits` for the same block.
- R6: When the original and predictor blocks are identical, `satd_out` is 0 and `cost_out` is the rate term alone.
- R7: For any 8-bit pixel values, `satd_out` never exceeds 32640 and wraps in neither output. A flat full-scale residual of ±255 gives 2040.
- R8: On cycles where no block reaches the output, `satd_out` and `cost_out` keep the last values delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A block is presented this cycle |
| orig | input | 128 | Original pixels, 16 x 8 bits, raster order |
| pred | input | 128 | Predictor pixels, 16 x 8 bits, raster order |
| sub_en | input | 1 | Use the subsampled residual |
| lambda | input | 8 | Rate multiplier |
| mode_bits | input | 4 | Bit count of the mode information |
| satd_out | output | 15 | Halved sum of absolute transform coefficients |
| satd_valid | output | 1 | `satd_out` carries a new result |
| cost_out | output | 16 | SATD plus rate term |
| cost_valid | output | 1 | `cost_out` carries a new result |

## Verification
The assertions assume that the data inputs are known whenever `in_valid` is high. The zero-residual check also assumes that equal buses mean a perfect prediction in both residual modes. The bench drives every input on the falling edge, so these hold. It mixes seeded random pixels with directed blocks: identical blocks, flat full-scale residuals, a checkerboard, and a single residual placed where subsampling discards it. It also puts idle cycles between bursts, so that holding the output can be observed.

// File: rtl/satd4x4.sv
module satd4x4 #(
  parameter int PW    = 8,
  parameter int LAM_W = 8,
  parameter int MB_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [16*PW-1:0]     orig,
  input  logic [16*PW-1:0]     pred,
  input  logic                 sub_en,
  input  logic [LAM_W-1:0]     lambda,
  input  logic [MB_W-1:0]      mode_bits,
  output logic [PW+6:0]        satd_out,
  output logic                 satd_valid,
  output logic [((PW+7 > LAM_W+MB_W) ? PW+7 : LAM_W+MB_W):0] cost_out,
  output logic                 cost_valid
);
  localparam int RW     = PW + 1;
  localparam int CW1    = PW + 3;
  localparam int CW2    = PW + 5;
  localparam int SW     = PW + 8;
  localparam int SATD_W = PW + 7;
  localparam int RATE_W = LAM_W + MB_W;
  localparam int COST_W = ((SATD_W > RATE_W) ? SATD_W : RATE_W) + 1;
  localparam int MAXS   = 8 * 16 * ((1 << PW) - 1);

  logic signed [RW-1:0]  res_d [16];
  logic signed [RW-1:0]  res_q [16];
  logic signed [CW1-1:0] row_d [16];
  logic signed [CW1-1:0] row_q [16];
  logic [SW-1:0]         sum_d;
  logic [RATE_W-1:0]     rate1_q, rate2_q;
  logic                  v1, v2;
  logic [1:0]            age;

  always_comb begin
    for (int k = 0; k < 16; k++) begin
      int y, x, src;
      y = k / 4;
      x = k % 4;
      src = sub_en ? (y * 4 + ((x & 2) | (y & 1))) : k;
      res_d[k] = $signed({1'b0, orig[src*PW +: PW]}) - $signed({1'b0, pred[src*PW +: PW]});
    end
  end

  always_comb begin
    for (int y = 0; y < 4; y++) begin
      logic signed [CW1-1:0] e0, e1, e2, e3;
      e0 = CW1'(res_q[4*y+0]) + CW1'(res_q[4*y+1]);
      e1 = CW1'(res_q[4*y+0]) - CW1'(res_q[4*y+1]);
      e2 = CW1'(res_q[4*y+2]) + CW1'(res_q[4*y+3]);
      e3 = CW1'(res_q[4*y+2]) - CW1'(res_q[4*y+3]);
      row_d[4*y+0] = e0 + e2;
      row_d[4*y+1] = e1 + e3;
      row_d[4*y+2] = e0 - e2;
      row_d[4*y+3] = e1 - e3;
    end
  end

  always_comb begin
    sum_d = '0;
    for (int x = 0; x < 4; x++) begin
      logic signed [CW2-1:0] f0, f1, f2, f3;
      logic signed [CW2-1:0] c [4];
      f0 = CW2'(row_q[x]) + CW2'(row_q[4+x]);
      f1 = CW2'(row_q[x]) - CW2'(row_q[4+x]);
      f2 = CW2'(row_q[8+x]) + CW2'(row_q[12+x]);
      f3 = CW2'(row_q[8+x]) - CW2'(row_q[12+x]);
      c[0] = f0 + f2;
      c[1] = f1 + f3;
      c[2] = f0 - f2;
      c[3] = f1 - f3;
      for (int j = 0; j < 4; j++) begin
        logic [CW2-1:0] mag;
        mag = c[j][CW2-1] ? CW2'(-c[j]) : CW2'(c[j]);
        sum_d = sum_d + {{(SW-CW2){1'b0}}, mag};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      satd_valid <= 1'b0;
      cost_valid <= 1'b0;
      satd_out <= '0;
      cost_out <= '0;
      rate1_q <= '0;
      rate2_q <= '0;
      age <= '0;
      for (int k = 0; k < 16; k++) begin
        res_q[k] <= '0;
        row_q[k] <= '0;
      end
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      satd_valid <= v2;
      cost_valid <= v2;
      if (age != 2'd3) age <= age + 2'd1;
      if (in_valid) begin
        res_q <= res_d;
        rate1_q <= RATE_W'(lambda) * RATE_W'(mode_bits);
      end
      if (v1) begin
        row_q <= row_d;
        rate2_q <= rate1_q;
      end
      if (v2) begin
        satd_out <= sum_d[SW-1:1];
        cost_out <= COST_W'(sum_d[SW-1:1]) + COST_W'(rate2_q);
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (satd_valid == $past(in_valid, 3)));

  p_cost_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cost_valid |-> (cost_out >= COST_W'(satd_out)));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && $past(in_valid && (orig == pred), 3)) |-> (satd_out == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    satd_out <= SATD_W'(MAXS));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((age != 2'd0) && !$past(v2)) |-> ($stable(satd_out) && $stable(cost_out)));

  p_valid_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    satd_valid == cost_valid);
endmodule

// File: tb/satd4x4_bench.sv
module satd4x4_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] orig = '0, pred = '0;
  logic sub_en = 1'b0;
  logic [7:0] lambda = '0;
  logic [3:0] mode_bits = '0;
  logic [14:0] satd_out;
  logic satd_valid;
  logic [15:0] cost_out;
  logic cost_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  bit ev_v [3];
  int ev_s [3];
  int ev_c [3];
  bit ev_sub [3];
  int last_s = 0, last_c = 0;

  always #4 clk = ~clk;

  satd4x4 u_satd4x4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .orig(orig), .pred(pred),
    .sub_en(sub_en), .lambda(lambda), .mode_bits(mode_bits),
    .satd_out(satd_out), .satd_valid(satd_valid),
    .cost_out(cost_out), .cost_valid(cost_valid));

  function automatic int satd_ref(logic [127:0] o, logic [127:0] p, bit sub);
    int d [4][4];
    int t [4][4];
    int h [4][4];
    int s;
    h = '{'{1,1,1,1}, '{1,1,-1,-1}, '{1,-1,-1,1}, '{1,-1,1,-1}};
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) begin
        int sx;
        sx = sub ? ((x / 2) * 2 + (y % 2)) : x;
        d[y][x] = int'(o[(4*y+sx)*8 +: 8]) - int'(p[(4*y+sx)*8 +: 8]);
      end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        t[i][j] = 0;
        for (int k = 0; k < 4; k++) t[i][j] += h[i][k] * d[k][j];
      end
    s = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int c;
        c = 0;
        for (int k = 0; k < 4; k++) c += t[i][k] * h[j][k];
        s += (c < 0) ? -c : c;
      end
    return s >> 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [127:0] o, logic [127:0] p, bit s, logic [7:0] l, logic [3:0] m);
    @(negedge clk);
    check(satd_valid == ev_v[2], "R2 satd_valid", satd_valid, ev_v[2]);
    check(cost_valid == ev_v[2], "R2 cost_valid", cost_valid, ev_v[2]);
    if (ev_v[2]) begin
      check(satd_out == ev_s[2], ev_sub[2] ? "R4 satd" : "R3 satd", satd_out, ev_s[2]);
      check(cost_out == ev_c[2], "R5 cost", cost_out, ev_c[2]);
      last_s = ev_s[2];
      last_c = ev_c[2];
    end else begin
      check(satd_out == last_s && cost_out == last_c, "R8 hold", satd_out, last_s);
    end
    for (int i = 2; i > 0; i--) begin
      ev_v[i] = ev_v[i-1]; ev_s[i] = ev_s[i-1]; ev_c[i] = ev_c[i-1]; ev_sub[i] = ev_sub[i-1];
    end
    ev_v[0] = v;
    ev_sub[0] = s;
    ev_s[0] = satd_ref(o, p, s);
    ev_c[0] = ev_s[0] + int'(l) * int'(m);
    in_valid = v; orig = o; pred = p; sub_en = s; lambda = l; mode_bits = m;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, cb;
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) begin ev_v[i] = 0; ev_s[i] = 0; ev_c[i] = 0; ev_sub[i] = 0; end
    repeat (3) @(negedge clk);
    check(satd_valid == 0 && cost_valid == 0, "R1 valid in reset", satd_valid, 0);
    check(satd_out == 0 && cost_out == 0, "R1 data in reset", satd_out, 0);
    rst_n = 1'b1;
    repeat (3) step(0, '0, '0, 0, 0, 0);
    check(satd_out == 0 && cost_out == 0, "R1 data after reset", cost_out, 0);
    a = rnd128();
    // R6: identical blocks
    step(1, a, a, 0, 8'd20, 4'd3);
    step(1, a, a, 1, 8'd7, 4'd9);
    // R7: flat full-scale residual both signs, rate at maximum
    step(1, {16{8'hFF}}, '0, 0, 8'd255, 4'd15);
    step(1, '0, {16{8'hFF}}, 1, 8'd255, 4'd15);
    cb = '0;
    for (int k = 0; k < 16; k++) if (((k / 4) + (k % 4)) % 2 == 1) cb[k*8 +: 8] = 8'hFF;
    step(1, cb, '0, 0, 8'd1, 4'd1);
    step(1, cb, '0, 1, 8'd1, 4'd1);
    // R4: residual only at position (0,1), discarded by subsampling
    b = '0; b[8 +: 8] = 8'hFF;
    step(1, b, '0, 0, 8'd3, 4'd2);
    step(1, b, '0, 1, 8'd3, 4'd2);
    repeat (4) step(0, rnd128(), rnd128(), 0, 8'd9, 4'd9);
    check(last_s == 0, "R4 discarded residual", last_s, 0);
    for (int n = 0; n < 600; n++) begin
      bit v;
      logic [127:0] o, p;
      v = ($urandom % 4) != 0;
      o = rnd128();
      p = (($urandom % 8) == 0) ? o : rnd128();
      step(v, o, p, $urandom % 2, 8'($urandom), 4'($urandom));
    end
    repeat (4) step(0, '0, '0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule